// File: doc/BRIEF.md
# Asynchronous Serial Transmit Channel

This block is one transmit channel of an asynchronous serial port. A host drives it through a small register interface. The interface holds a data register, a control register with a line-enable bit and an interrupt-enable bit, a status register with a buffer-empty flag and a line-finished flag, and a register for a general-purpose port bit. A baud tick input paces the output. Each bit of a character is held for a fixed number of ticks. Characters go out with a low start bit, eight data bits least significant first, and a high stop bit.

The host hands a byte to the transmitter in three steps. It reads the status register and sees the empty flag at 1. It writes the data register. It then writes 0 to the empty flag. A hardware transfer agent can instead write the data register through a dedicated strobe, typically in answer to the empty interrupt; that write clears the flag by itself. When the line is enabled, the output pin first carries one whole idle character time of ones. While the line is disabled, the pin follows the port bit, so a break is made by driving the port bit low and then disabling the line.

Top module: `sertx_chan`

## Requirements
- R1: After reset the pin is high, the line is disabled, the interrupt is low, and status reads empty=1 (bit 1) and finished=1 (bit 0).
- R2: When the enable bit (control bit 0) goes from 0 to 1, the pin is held high for 10 × TICKS_PER_BIT baud ticks, and no character starts before that time has passed.
- R3: A write of 0 to status bit 1 clears the empty flag only if status was read with empty=1 since the last status write. Writes of 1 to that bit never change the flag.
- R4: A transfer-agent write loads the data register and clears the empty flag in the same cycle, with no status write.
- R5: While enabled and idle with empty=0, the next baud tick moves the data register into the shifter, starts the start bit, and sets empty back to 1.
- R6: A character is a 0 start bit, data bits 0 to 7 in that order, then a 1 stop bit, each held for TICKS_PER_BIT baud ticks.
- R7: The finished flag clears whenever the empty flag is cleared. It sets at the final tick of a stop bit if empty is still 1.
- R8: If empty is 0 when a stop bit ends, the next start bit follows on that same tick, with no idle gap.
- R9: While disabled, the pin equals the port data bit (port bit 1) when the port direction bit (port bit 0) is 1, and is high otherwise. A low port bit therefore gives a steady break.
- R10: The interrupt is high exactly when the line is enabled, the interrupt-enable bit (control bit 1) is 1, and empty is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_tick | input | 1 | One-cycle pulse per baud sub-period |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; arms the empty-flag clear |
| reg_sel | input | 2 | 0 data, 1 control, 2 status, 3 port |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| agent_wr | input | 1 | Transfer-agent data write strobe |
| agent_data | input | 8 | Transfer-agent write data |
| irq | output | 1 | Data-empty interrupt request |
| txd | output | 1 | Serial output pin |

## Verification
The assertions rely on the host and the agent never clearing the empty flag while it is already 0. They also rely on a read strobe and a write strobe never arriving together. The bench keeps within these limits. It writes one strobe per cycle. It issues an agent write only after the empty flag has come back to 1. It does a status read and a status write in separate cycles. A behavioural model tracks phases as tick counts rather than bit counters. The pin and the interrupt are compared with it every cycle, and status reads are compared with it at each step.

// File: rtl/sertx_chan.sv
module sertx_chan #(
  parameter int TICKS_PER_BIT = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       baud_tick,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [1:0] reg_sel,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       agent_wr,
  input  logic [7:0] agent_data,
  output logic       irq,
  output logic       txd
);
  localparam int CW = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1;
  localparam int FRAME_BITS = 10;

  typedef enum logic [1:0] {S_IDLE, S_PRE, S_SEND} st_t;

  st_t         st;
  logic [CW-1:0] cnt;
  logic [3:0]  idx;
  logic [9:0]  shreg;
  logic [7:0]  data_q;
  logic        tx_on, irq_en, port_dir, port_val;
  logic        empty, done, armed;

  wire ctrl_wr   = reg_wr && reg_sel == 2'd1;
  wire stat_wr   = reg_wr && reg_sel == 2'd2;
  wire toggle    = ctrl_wr && (reg_wdata[0] != tx_on);
  wire bit_end   = baud_tick && cnt == CW'(TICKS_PER_BIT - 1);
  wire frame_end = bit_end && idx == 4'(FRAME_BITS - 1);
  wire stop_end  = st == S_SEND && frame_end && !toggle;
  wire load      = tx_on && !toggle && baud_tick && !empty &&
                   (st == S_IDLE || (st == S_SEND && frame_end));
  wire clear     = agent_wr || (stat_wr && !reg_wdata[1] && armed);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      cnt   <= '0;
      idx   <= '0;
      shreg <= '1;
    end else if (toggle) begin
      st  <= reg_wdata[0] ? S_PRE : S_IDLE;
      cnt <= '0;
      idx <= '0;
    end else if (load) begin
      shreg <= {1'b1, data_q, 1'b0};
      st    <= S_SEND;
      cnt   <= '0;
      idx   <= '0;
    end else if (baud_tick && st != S_IDLE) begin
      if (bit_end) begin
        cnt <= '0;
        if (frame_end) st <= S_IDLE;
        else idx <= idx + 4'd1;
        if (st == S_SEND) shreg <= {1'b1, shreg[9:1]};
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_on <= 1'b0; irq_en <= 1'b0; port_dir <= 1'b0; port_val <= 1'b0;
      empty <= 1'b1; done <= 1'b1; armed <= 1'b0; data_q <= '0;
    end else begin
      if (ctrl_wr) begin
        tx_on  <= reg_wdata[0];
        irq_en <= reg_wdata[1];
      end
      if (reg_wr && reg_sel == 2'd3) begin
        port_dir <= reg_wdata[0];
        port_val <= reg_wdata[1];
      end
      if (agent_wr) data_q <= agent_data;
      else if (reg_wr && reg_sel == 2'd0) data_q <= reg_wdata;

      if (load) empty <= 1'b1;
      else if (clear) empty <= 1'b0;

      if (clear) done <= 1'b0;
      else if (stop_end && empty) done <= 1'b1;

      if (reg_rd && reg_sel == 2'd2 && empty) armed <= 1'b1;
      else if (stat_wr || !empty) armed <= 1'b0;
    end
  end

  always_comb begin
    case (reg_sel)
      2'd0:    reg_rdata = data_q;
      2'd1:    reg_rdata = {6'b0, irq_en, tx_on};
      2'd2:    reg_rdata = {6'b0, empty, done};
      default: reg_rdata = {6'b0, port_val, port_dir};
    endcase
  end

  assign irq = tx_on && irq_en && empty;
  assign txd = tx_on ? ((st == S_SEND) ? shreg[0] : 1'b1)
                     : (port_dir ? port_val : 1'b1);

  // R2
  preamble_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_PRE |-> txd);
  // R5
  load_sets_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> empty && st == S_SEND && !txd);
  // R7
  done_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(empty) |-> !done);
  // R3
  write_one_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && reg_wdata[1] && !agent_wr && !empty && !load) |=> !empty);
  // R6
  start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st == S_SEND) |-> !txd);
  // R9
  break_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_on && port_dir && !port_val) |-> !txd);
  // R10
  irq_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_on |-> !irq);
endmodule

// File: tb/sim_sertx_chan.sv
module sim_sertx_chan;
  localparam int TPB = 16;
  localparam int FT = 10 * TPB;

  logic clk = 0, rst_n = 0, baud_tick = 0;
  logic reg_wr = 0, reg_rd = 0, agent_wr = 0;
  logic [1:0] reg_sel = 0;
  logic [7:0] reg_wdata = 0, agent_data = 0, reg_rdata;
  logic irq, txd;

  sertx_chan #(.TICKS_PER_BIT(TPB)) u0 (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .agent_wr(agent_wr), .agent_data(agent_data),
    .irq(irq), .txd(txd));

  always #5 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0, tcnt = 0;
  bit running = 0;

  // behavioural reference
  bit m_on, m_ie, m_dir, m_val, m_empty, m_done, m_armed;
  int m_data, m_phase, m_t;
  bit [9:0] m_frame;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_on = 0; m_ie = 0; m_dir = 0; m_val = 0; m_empty = 1; m_done = 1;
      m_armed = 0; m_data = 0; m_phase = 0; m_t = 0; m_frame = '1;
    end else begin
      bit cw, sw, tg, ld, fe, cl, oe;
      cw = reg_wr && reg_sel == 1;
      sw = reg_wr && reg_sel == 2;
      tg = cw && (reg_wdata[0] != m_on);
      ld = m_on && !tg && baud_tick && !m_empty &&
           (m_phase == 0 || (m_phase == 2 && m_t == FT - 1));
      fe = m_phase == 2 && baud_tick && m_t == FT - 1 && !tg;
      cl = agent_wr || (sw && !reg_wdata[1] && m_armed);
      oe = m_empty;
      if (tg) begin m_phase = reg_wdata[0] ? 1 : 0; m_t = 0; end
      else if (ld) begin m_phase = 2; m_t = 0; m_frame = {1'b1, m_data[7:0], 1'b0}; end
      else if (baud_tick && m_phase != 0) begin
        if (m_t == FT - 1) begin m_phase = 0; m_t = 0; end else m_t++;
      end
      if (ld) m_empty = 1; else if (cl) m_empty = 0;
      if (cl) m_done = 0; else if (fe && oe) m_done = 1;
      if (reg_rd && reg_sel == 2 && oe) m_armed = 1;
      else if (sw || !oe) m_armed = 0;
      if (agent_wr) m_data = agent_data;
      else if (reg_wr && reg_sel == 0) m_data = reg_wdata;
      if (cw) begin m_on = reg_wdata[0]; m_ie = reg_wdata[1]; end
      if (reg_wr && reg_sel == 3) begin m_dir = reg_wdata[0]; m_val = reg_wdata[1]; end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    tcnt <= tcnt + 1;
    baud_tick <= ((tcnt % 4) == 3);
    cyc <= cyc + 1;
    if (cyc > 200000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
    if (running) begin
      bit et;
      string tg;
      et = m_on ? ((m_phase == 2) ? m_frame[m_t / TPB] : 1'b1) : (m_dir ? m_val : 1'b1);
      tg = !m_on ? "R9 pin" : (m_phase == 2 ? "R6 frame" : "R2 idle");
      chk(txd == et, tg, txd, et);
      chk(irq == (m_on && m_ie && m_empty), "R10 irq", irq, m_on && m_ie && m_empty);
    end
  end

  task automatic wr(input bit [1:0] s, input bit [7:0] d);
    @(negedge clk); reg_wr = 1; reg_sel = s; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd_stat(output bit [1:0] v);
    @(negedge clk); reg_rd = 1; reg_sel = 2; #1 v = reg_rdata[1:0];
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic stat_chk(input string tag);
    bit [1:0] v;
    rd_stat(v);
    chk(v == {m_empty, m_done}, tag, v, {m_empty, m_done});
  endtask

  task automatic wait_empty();
    int n = 0;
    while (!m_empty && n < 5000) begin @(negedge clk); n++; end
  endtask

  initial begin
    bit [1:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk(txd == 1 && irq == 0, "R1 reset pins", {txd, irq}, 2);
    reg_sel = 2; #1;
    chk(reg_rdata[1:0] == 2'b11, "R1 reset status", reg_rdata[1:0], 3);
    running = 1;

    wr(3, 8'h01);
    @(negedge clk) chk(txd == 0, "R9 break while off", txd, 0);
    wr(3, 8'h03);
    @(negedge clk) chk(txd == 1, "R9 port high", txd, 1);
    wr(3, 8'h00);

    wr(1, 8'h03);
    chk(irq == 1, "R10 irq on enable", irq, 1);
    wr(0, 8'hA5);
    wr(2, 8'h00);
    stat_chk("R3 unarmed clear ignored");
    chk(m_empty == 1, "R3 model empty", m_empty, 1);
    rd_stat(v);
    wr(2, 8'h02);
    stat_chk("R3 write one ignored");
    rd_stat(v);
    wr(2, 8'h00);
    stat_chk("R7 done cleared with empty");
    chk(m_empty == 0, "R3 armed clear took", m_empty, 0);
    wait_empty();
    chk(txd == 0, "R5 start after load", txd, 0);
    chk(m_phase == 2 && m_t == 0, "R2 no load before preamble", m_phase, 2);

    repeat (40) @(negedge clk);
    @(negedge clk); agent_wr = 1; agent_data = 8'h3C;
    @(negedge clk); agent_wr = 0;
    stat_chk("R4 agent clears empty");
    chk(m_empty == 0, "R4 model", m_empty, 0);
    wait_empty();
    chk(txd == 0, "R8 back to back start", txd, 0);
    stat_chk("R5 empty set on load");

    begin
      int n = 0;
      while (!m_done && n < 5000) begin @(negedge clk); n++; end
    end
    stat_chk("R7 done at stop end");

    wr(1, 8'h00);
    wr(0, 8'h81);
    rd_stat(v);
    wr(2, 8'h00);
    wr(1, 8'h01);
    wait_empty();
    stat_chk("R6 third frame loaded");
    repeat (700) @(negedge clk);
    stat_chk("R7 third frame done");

    wr(3, 8'h01);
    wr(1, 8'h00);
    repeat (20) @(negedge clk);
    chk(txd == 0, "R9 steady break", txd, 0);
    chk(irq == 0, "R10 irq off", irq, 0);

    running = 0;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule